// File: doc/BRIEF.md
# Asynchronous Memory Write Sequencer

This block turns one word-wide write request into the pin activity an external asynchronous memory or peripheral expects. The pins are a chip select, a write strobe, an output enable and active-low byte masks, alongside an address bus and a data bus. Each request passes through four phases: turnaround, setup, strobe and hold. Their lengths come from a per-bank timing configuration supplied with the request. The external device can hold the strobe phase open with an active-low wait input, which is synchronized inside the block.

The device data bus may be narrower than the request word. In that case the word is sent as several back-to-back accesses, lowest part first, and chip select stays low between them. An upstream arbiter supplies two things: a qualifier saying the request is still the most urgent task, and the type of the operation that came before it. These set how much turnaround is inserted and whether the request goes ahead once turnaround ends. If a new request is waiting when the last access finishes, it is taken without passing through idle.

Top module: `asram_wr_seq`

## Requirements
- R1: `mem_oe_n` is high in every cycle, including during reset and during every phase of a write.
- R2: Turnaround length depends on `req_prev`, encoded as 0 = none, 1 = read, 2 = write. For 2 it is 0 cycles. For 1 it is `cfg_turn` cycles, or 1 cycle when `cfg_turn` is 0. For 0 or 3 it is `cfg_turn` cycles. Chip select is high throughout turnaround.
- R3: `req_win` is sampled in the last turnaround cycle, or in the accept cycle when turnaround is 0 cycles. If it is low, the request ends: `wr_abort` pulses for one cycle in the next cycle, and chip select never falls for that request.
- R4: Setup lasts `cfg_setup`+1 cycles. During setup chip select is low, `mem_we_n` is high, `mem_dout_en` is high, and address and data are valid.
- R5: Strobe lasts `cfg_strobe`+1 cycles with `mem_we_n` low. During strobe `mem_bm_n` is the inverse of the byte enables for the current access. Outside strobe every `mem_bm_n` bit is high. Address and data stay stable throughout strobe.
- R6: `mem_wait_n` (active low) passes through a two-flop synchronizer. Strobe cannot end at a clock edge where the synchronized wait is active. If wait is released K cycles into strobe, strobe lasts max(`cfg_strobe`+1, K+2) cycles.
- R7: Hold lasts `cfg_hold`+1 cycles with `mem_we_n` high and chip select low. After the final hold, chip select rises, `mem_dout_en` falls and `wr_done` pulses high for exactly one cycle.
- R8: With a bus DEV_W bits wide, a word is sent as DATA_W/DEV_W accesses. Access i has `mem_addr` = {word address, i}, data = word bits [i*DEV_W +: DEV_W] and byte enables bits [i*DEV_W/8 +: DEV_W/8]. Accesses go out in ascending i. Each access after the first re-enters setup straight from hold, with no turnaround and with chip select held low.
- R9: Setup, strobe and hold counts are captured on entry to the first setup of a request. Changes to `cfg_setup`, `cfg_strobe` or `cfg_hold` after that point do not alter the later accesses of the same request.
- R10: If `req_valid` is high in the last cycle of the final hold, that request is accepted in that cycle. With `req_prev` = 2 and `req_win` high, its setup starts in the next cycle, chip select stays low, and the new address is already driven.
- R11: `req_ack` is high only in a cycle where the request fields are captured: an idle cycle, or the last cycle of the final hold, in either case with `req_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request pending |
| req_ack | output | 1 | Request captured this cycle |
| req_win | input | 1 | Request is still the most urgent task |
| req_prev | input | 2 | Previous operation: 0 none, 1 read, 2 write |
| req_addr | input | ADDR_W | Word address |
| req_data | input | DATA_W | Write word |
| req_be | input | DATA_W/8 | Byte enables, active high |
| cfg_turn | input | TA_W | Turnaround count |
| cfg_setup | input | SU_W | Setup count (count+1 cycles) |
| cfg_strobe | input | ST_W | Strobe count (count+1 cycles) |
| cfg_hold | input | HD_W | Hold count (count+1 cycles) |
| mem_wait_n | input | 1 | Asynchronous wait from the device, active low |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, held high |
| mem_bm_n | output | DEV_W/8 | Byte masks, active low during strobe |
| mem_addr | output | ADDR_W+log2(DATA_W/DEV_W) | Device address |
| mem_dout | output | DEV_W | Device write data |
| mem_dout_en | output | 1 | Data bus drive enable |
| wr_done | output | 1 | One-cycle pulse after the final hold |
| wr_abort | output | 1 | One-cycle pulse when priority is lost |

## Verification
The hardest situation to reach is a second request that lands exactly in the last cycle of the final hold. In that case the accept, the done pulse and the next setup have to line up with no idle cycle between them. The bench holds `req_valid` high across the whole first request and swaps in the second request's fields one edge after the first accept. It then checks that the acknowledge arrives while chip select is still low, and that the new address appears in the cycle of the done pulse. The wait and mid-request configuration cases use a forked process that watches for the first strobe cycle. That process releases the wait input, or rewrites the timing inputs, at a known cycle offset, so the expected strobe length and the lengths of the second access follow from R6 and R9.

// File: rtl/asw_pkg.sv
package asw_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_TURN,
      PH_SETUP,
      PH_STROBE,
      PH_HOLD
   } asw_phase_e;

   localparam logic [1:0] PREV_NONE  = 2'd0;
   localparam logic [1:0] PREV_READ  = 2'd1;
   localparam logic [1:0] PREV_WRITE = 2'd2;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/asw_sync.sv
module asw_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $fatal(1, "asw_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= {STAGES{RST_VAL}};
      else        sr_q <= {sr_q[STAGES-2:0], d};
   end

   assign q = sr_q[STAGES-1];
endmodule

// File: rtl/asw_phase_timer.sv
module asw_phase_timer #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/asw_lane_sel.sv
module asw_lane_sel #(
   parameter int DATA_W = 32,
   parameter int DEV_W  = 16,
   parameter int SUB_IW = 1
) (
   input  logic [DATA_W-1:0]   word,
   input  logic [DATA_W/8-1:0] be,
   input  logic [SUB_IW-1:0]   sub,
   output logic [DEV_W-1:0]    lane,
   output logic [DEV_W/8-1:0]  lane_bm_n
);
   localparam int SUBS = DATA_W / DEV_W;
   localparam int LB   = DEV_W / 8;

   generate
      if (SUBS == 1) begin : g_full
         logic unused_sub;
         assign unused_sub = ^sub;
         assign lane      = word;
         assign lane_bm_n = ~be;
      end else begin : g_split
         always_comb begin
            lane      = word[int'(sub)*DEV_W +: DEV_W];
            lane_bm_n = ~be[int'(sub)*LB +: LB];
         end
      end
   endgenerate
endmodule

// File: rtl/asram_wr_seq.sv
module asram_wr_seq
   import asw_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 32,
   parameter int DEV_W  = 16,
   parameter int TA_W   = 3,
   parameter int SU_W   = 4,
   parameter int ST_W   = 6,
   parameter int HD_W   = 3,
   localparam int SUBS  = DATA_W / DEV_W,
   localparam int MAW   = ADDR_W + $clog2(SUBS),
   localparam int LB    = DEV_W / 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ack,
   input  logic                req_win,
   input  logic [1:0]          req_prev,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_data,
   input  logic [DATA_W/8-1:0] req_be,
   input  logic [TA_W-1:0]     cfg_turn,
   input  logic [SU_W-1:0]     cfg_setup,
   input  logic [ST_W-1:0]     cfg_strobe,
   input  logic [HD_W-1:0]     cfg_hold,
   input  logic                mem_wait_n,
   output logic                mem_cs_n,
   output logic                mem_we_n,
   output logic                mem_oe_n,
   output logic [LB-1:0]       mem_bm_n,
   output logic [MAW-1:0]      mem_addr,
   output logic [DEV_W-1:0]    mem_dout,
   output logic                mem_dout_en,
   output logic                wr_done,
   output logic                wr_abort
);
   localparam int SUB_IW = (SUBS > 1) ? $clog2(SUBS) : 1;
   localparam int CW     = max2(max2(TA_W, SU_W), max2(ST_W, HD_W));

   generate
      if (DEV_W != 8 && DEV_W != 16 && DEV_W != 32) begin : g_bad_dev
         $fatal(1, "DEV_W must be 8, 16 or 32");
      end
      if (DATA_W < DEV_W || (DATA_W % DEV_W) != 0 || SUBS > 4) begin : g_bad_ratio
         $fatal(1, "DATA_W must be DEV_W times 1, 2 or 4");
      end
   endgenerate

   asw_phase_e          phase_q, nxt;
   logic [ADDR_W-1:0]   addr_q;
   logic [DATA_W-1:0]   data_q;
   logic [DATA_W/8-1:0] be_q;
   logic [SUB_IW-1:0]   sub_q;
   logic [SU_W-1:0]     su_q;
   logic [ST_W-1:0]     st_q;
   logic [HD_W-1:0]     hd_q;
   logic                done_q, abort_q;

   logic                wait_sync, wait_act;
   logic                t_load, t_zero;
   logic [CW-1:0]       t_lval;
   logic                accept, latch_cfg, sub_inc, do_done, do_abort;
   logic                last_sub;
   logic [TA_W-1:0]     turn_len;

   asw_phase_e          br_nxt;
   logic [CW-1:0]       br_lval;
   logic                br_latch, br_abort;

   asw_sync #(.STAGES(2), .RST_VAL(1'b1)) u_wait_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (mem_wait_n),
      .q    (wait_sync)
   );
   assign wait_act = ~wait_sync;

   asw_phase_timer #(.W(CW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (t_load),
      .load_val(t_lval),
      .zero    (t_zero)
   );

   assign last_sub = (sub_q == SUB_IW'(SUBS - 1));

   // turnaround length chosen by the previous operation type
   always_comb begin
      if (req_prev == PREV_WRITE)                         turn_len = '0;
      else if (req_prev == PREV_READ && cfg_turn == '0)   turn_len = TA_W'(1);
      else                                                turn_len = cfg_turn;
   end

   // outcome of capturing a new request
   always_comb begin
      br_nxt   = PH_TURN;
      br_lval  = CW'(turn_len - TA_W'(1));
      br_latch = 1'b0;
      br_abort = 1'b0;
      if (turn_len == '0) begin
         if (req_win) begin
            br_nxt   = PH_SETUP;
            br_lval  = CW'(cfg_setup);
            br_latch = 1'b1;
         end else begin
            br_nxt   = PH_IDLE;
            br_lval  = '0;
            br_abort = 1'b1;
         end
      end
   end

   always_comb begin
      nxt       = phase_q;
      accept    = 1'b0;
      t_load    = 1'b0;
      t_lval    = '0;
      latch_cfg = 1'b0;
      sub_inc   = 1'b0;
      do_done   = 1'b0;
      do_abort  = 1'b0;
      unique case (phase_q)
         PH_IDLE: begin
            if (req_valid) begin
               accept    = 1'b1;
               nxt       = br_nxt;
               t_load    = 1'b1;
               t_lval    = br_lval;
               latch_cfg = br_latch;
               do_abort  = br_abort;
            end
         end
         PH_TURN: begin
            if (t_zero) begin
               if (req_win) begin
                  nxt       = PH_SETUP;
                  t_load    = 1'b1;
                  t_lval    = CW'(cfg_setup);
                  latch_cfg = 1'b1;
               end else begin
                  nxt      = PH_IDLE;
                  do_abort = 1'b1;
               end
            end
         end
         PH_SETUP: begin
            if (t_zero) begin
               nxt    = PH_STROBE;
               t_load = 1'b1;
               t_lval = CW'(st_q);
            end
         end
         PH_STROBE: begin
            if (t_zero && !wait_act) begin
               nxt    = PH_HOLD;
               t_load = 1'b1;
               t_lval = CW'(hd_q);
            end
         end
         PH_HOLD: begin
            if (t_zero) begin
               if (!last_sub) begin
                  nxt     = PH_SETUP;
                  t_load  = 1'b1;
                  t_lval  = CW'(su_q);
                  sub_inc = 1'b1;
               end else begin
                  do_done = 1'b1;
                  if (req_valid) begin
                     accept    = 1'b1;
                     nxt       = br_nxt;
                     t_load    = 1'b1;
                     t_lval    = br_lval;
                     latch_cfg = br_latch;
                     do_abort  = br_abort;
                  end else begin
                     nxt = PH_IDLE;
                  end
               end
            end
         end
         default: nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         addr_q  <= '0;
         data_q  <= '0;
         be_q    <= '0;
         sub_q   <= '0;
         su_q    <= '0;
         st_q    <= '0;
         hd_q    <= '0;
         done_q  <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         phase_q <= nxt;
         done_q  <= do_done;
         abort_q <= do_abort;
         if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
            be_q   <= req_be;
            sub_q  <= '0;
         end else if (sub_inc) begin
            sub_q  <= sub_q + 1'b1;
         end
         if (latch_cfg) begin
            su_q <= cfg_setup;
            st_q <= cfg_strobe;
            hd_q <= cfg_hold;
         end
      end
   end

   logic [LB-1:0] lane_bm_n;

   asw_lane_sel #(.DATA_W(DATA_W), .DEV_W(DEV_W), .SUB_IW(SUB_IW)) u_lane (
      .word     (data_q),
      .be       (be_q),
      .sub      (sub_q),
      .lane     (mem_dout),
      .lane_bm_n(lane_bm_n)
   );

   generate
      if (SUBS == 1) begin : g_addr_word
         assign mem_addr = addr_q;
      end else begin : g_addr_sub
         assign mem_addr = {addr_q, sub_q};
      end
   endgenerate

   logic driving;
   assign driving     = (phase_q == PH_SETUP) || (phase_q == PH_STROBE) || (phase_q == PH_HOLD);
   assign mem_cs_n    = ~driving;
   assign mem_we_n    = (phase_q != PH_STROBE);
   assign mem_oe_n    = 1'b1;
   assign mem_bm_n    = (phase_q == PH_STROBE) ? lane_bm_n : {LB{1'b1}};
   assign mem_dout_en = driving;
   assign req_ack     = accept;
   assign wr_done     = done_q;
   assign wr_abort    = abort_q;
endmodule

// File: rtl/asw_chk.sv
module asw_chk #(
   parameter int LB  = 2,
   parameter int MAW = 21,
   parameter int DW  = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           req_ack,
   input logic           req_win,
   input logic [1:0]     req_prev,
   input logic           mem_cs_n,
   input logic           mem_we_n,
   input logic [LB-1:0]  mem_bm_n,
   input logic [MAW-1:0] mem_addr,
   input logic [DW-1:0]  mem_dout,
   input logic           wr_done,
   input logic           wr_abort,
   input logic           wait_act
);
   a_r2_write_prev_no_turn: assert property (@(posedge clk) disable iff (!rst_n)
      (req_ack && req_prev == 2'd2 && req_win) |=> !mem_cs_n);

   a_r3_abort_no_select: assert property (@(posedge clk) disable iff (!rst_n)
      wr_abort |-> (mem_cs_n && $past(mem_cs_n)));

   a_r5_strobe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> !mem_cs_n);

   a_r5_mask_idle_outside: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_n |-> (&mem_bm_n));

   a_r5_stable_in_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));

   a_r6_wait_holds_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && wait_act) |=> !mem_we_n);

   a_r7_done_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |-> $past(!mem_cs_n && mem_we_n));

   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done |=> !wr_done);
endmodule

bind asram_wr_seq asw_chk #(.LB(LB), .MAW(MAW), .DW(DEV_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .req_ack (req_ack),
   .req_win (req_win),
   .req_prev(req_prev),
   .mem_cs_n(mem_cs_n),
   .mem_we_n(mem_we_n),
   .mem_bm_n(mem_bm_n),
   .mem_addr(mem_addr),
   .mem_dout(mem_dout),
   .wr_done (wr_done),
   .wr_abort(wr_abort),
   .wait_act(wait_act)
);

// File: tb/asram_wr_seq_tb.sv
`timescale 1ns/1ps
module asram_wr_seq_tb;
   localparam int ADDR_W = 20;
   localparam int DATA_W = 32;
   localparam int DEV_W  = 16;
   localparam int LB     = DEV_W / 8;
   localparam int MAW    = ADDR_W + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_win = 1'b1;
   logic [1:0] req_prev = 2'd0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [DATA_W-1:0] req_data = '0;
   logic [3:0] req_be = '0;
   logic [2:0] cfg_turn = '0;
   logic [3:0] cfg_setup = '0;
   logic [5:0] cfg_strobe = '0;
   logic [2:0] cfg_hold = '0;
   logic mem_wait_n = 1'b1;
   logic req_ack, mem_cs_n, mem_we_n, mem_oe_n, mem_dout_en, wr_done, wr_abort;
   logic [LB-1:0] mem_bm_n;
   logic [MAW-1:0] mem_addr;
   logic [DEV_W-1:0] mem_dout;

   int checks = 0, failures = 0, oe_bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   asram_wr_seq u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ack(req_ack),
      .req_win(req_win), .req_prev(req_prev), .req_addr(req_addr),
      .req_data(req_data), .req_be(req_be), .cfg_turn(cfg_turn),
      .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe), .cfg_hold(cfg_hold),
      .mem_wait_n(mem_wait_n), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
      .mem_oe_n(mem_oe_n), .mem_bm_n(mem_bm_n), .mem_addr(mem_addr),
      .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .wr_done(wr_done),
      .wr_abort(wr_abort)
   );

   // R1 monitor: output enable must never go low
   always @(negedge clk) if (mem_oe_n !== 1'b1) oe_bad++;

   task automatic ceq(input string rq, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // observation results
   int o_ta, o_nsub, o_en_bad;
   int o_su[4], o_st[4], o_hd[4];
   logic [MAW-1:0] o_a[4];
   logic [DEV_W-1:0] o_d[4];
   logic [LB-1:0] o_bm[4];
   bit o_done, o_abort, o_cs_end;
   logic [MAW-1:0] o_addr_end;

   task automatic issue(input logic [ADDR_W-1:0] a, input logic [31:0] d, input logic [3:0] be,
                        input logic [1:0] prev, input logic win, input int ta, input int su,
                        input int st, input int hd);
      req_addr = a; req_data = d; req_be = be; req_prev = prev; req_win = win;
      cfg_turn = 3'(ta); cfg_setup = 4'(su); cfg_strobe = 6'(st); cfg_hold = 3'(hd);
      req_valid = 1'b1;
      #0.1;
      while (!req_ack) @(negedge clk);
   endtask

   task automatic drop_valid();
      fork
         begin @(posedge clk); #0.5 req_valid = 1'b0; end
      join_none
   endtask

   // walks the phases after an acknowledge sample
   task automatic observe();
      int ph = 0, s = 0;
      logic [MAW-1:0] cur;
      o_ta = 0; o_nsub = 0; o_en_bad = 0; o_done = 0; o_abort = 0; o_cs_end = 0;
      o_addr_end = '0; cur = '0;
      for (int i = 0; i < 4; i++) begin o_su[i] = 0; o_st[i] = 0; o_hd[i] = 0; end
      for (int n = 0; n < 400; n++) begin
         @(negedge clk);
         if (ph == 0) begin
            if (wr_abort) begin o_abort = 1; break; end
            if (mem_cs_n) o_ta++;
            else begin ph = 1; o_su[0] = 1; cur = mem_addr; end
         end else if (ph == 1) begin
            if (!mem_we_n) begin
               ph = 2; o_st[s] = 1; o_a[s] = mem_addr; o_d[s] = mem_dout; o_bm[s] = mem_bm_n;
            end else o_su[s]++;
            if (!mem_dout_en) o_en_bad++;
         end else if (ph == 2) begin
            if (mem_we_n) begin ph = 3; o_hd[s] = 1; end
            else o_st[s]++;
         end else begin
            if (wr_done || mem_cs_n) begin
               o_done = wr_done; o_cs_end = mem_cs_n; o_addr_end = mem_addr; o_nsub = s + 1;
               break;
            end else if (mem_addr != cur) begin
               s++; ph = 1; o_su[s] = 1; cur = mem_addr;
            end else o_hd[s]++;
         end
      end
   endtask

   task automatic idle_gap();
      repeat (3) @(negedge clk);
   endtask

   task automatic test_reset();
      ceq("R1", "oe after reset", mem_oe_n, 1);
      ceq("R7", "cs idle after reset", mem_cs_n, 1);
      ceq("R5", "we idle after reset", mem_we_n, 1);
      ceq("R5", "masks idle after reset", mem_bm_n, 2'b11);
      ceq("R7", "done low after reset", wr_done, 0);
      ceq("R7", "dout_en low after reset", mem_dout_en, 0);
   endtask

   task automatic test_basic();
      issue(20'h12345, 32'hA1B2C3D4, 4'b1101, 2'd0, 1'b1, 3, 2, 3, 1);
      drop_valid();
      observe();
      ceq("R2", "turnaround prev none", o_ta, 3);
      ceq("R4", "setup cycles", o_su[0], 3);
      ceq("R4", "dout_en in setup", o_en_bad, 0);
      ceq("R5", "strobe cycles", o_st[0], 4);
      ceq("R7", "hold cycles", o_hd[0], 2);
      ceq("R8", "access count", o_nsub, 2);
      ceq("R8", "second setup cycles", o_su[1], 3);
      ceq("R8", "addr access0", o_a[0], {20'h12345, 1'b0});
      ceq("R8", "addr access1", o_a[1], {20'h12345, 1'b1});
      ceq("R8", "data access0", o_d[0], 16'hC3D4);
      ceq("R8", "data access1", o_d[1], 16'hA1B2);
      ceq("R5", "mask access0", o_bm[0], 2'b10);
      ceq("R5", "mask access1", o_bm[1], 2'b00);
      ceq("R7", "done pulse", o_done, 1);
      ceq("R7", "cs high after done", o_cs_end, 1);
      @(negedge clk);
      ceq("R7", "done one cycle", wr_done, 0);
      idle_gap();
   endtask

   task automatic test_prev_write();
      issue(20'h00100, 32'h11223344, 4'b1111, 2'd2, 1'b1, 3, 0, 0, 0);
      drop_valid();
      observe();
      ceq("R2", "turnaround prev write", o_ta, 0);
      ceq("R7", "done prev write", o_done, 1);
      idle_gap();
   endtask

   task automatic test_prev_read();
      issue(20'h00200, 32'h55667788, 4'b0011, 2'd1, 1'b1, 0, 0, 0, 0);
      drop_valid();
      observe();
      ceq("R2", "turnaround prev read ta0", o_ta, 1);
      idle_gap();
      issue(20'h00201, 32'h55667788, 4'b0011, 2'd1, 1'b1, 2, 0, 0, 0);
      drop_valid();
      observe();
      ceq("R2", "turnaround prev read ta2", o_ta, 2);
      idle_gap();
   endtask

   task automatic test_abort();
      issue(20'h00300, 32'h0, 4'b1111, 2'd0, 1'b0, 2, 1, 1, 1);
      drop_valid();
      observe();
      ceq("R3", "abort after turnaround", o_abort, 1);
      ceq("R3", "no select before abort", o_ta, 2);
      @(negedge clk);
      ceq("R3", "abort one cycle", wr_abort, 0);
      ceq("R3", "cs still high", mem_cs_n, 1);
      idle_gap();
      issue(20'h00301, 32'h0, 4'b1111, 2'd2, 1'b0, 5, 1, 1, 1);
      drop_valid();
      observe();
      ceq("R3", "abort zero turnaround", o_abort, 1);
      ceq("R3", "abort zero turnaround ta", o_ta, 0);
      req_win = 1'b1;
      idle_gap();
   endtask

   task automatic test_wait();
      mem_wait_n = 1'b0;
      repeat (3) @(negedge clk);
      issue(20'h00400, 32'hDEADBEEF, 4'b1111, 2'd0, 1'b1, 0, 1, 1, 0);
      drop_valid();
      fork
         begin
            @(negedge clk);
            while (mem_we_n) @(negedge clk);
            repeat (4) @(negedge clk);
            mem_wait_n = 1'b1;
         end
      join_none
      observe();
      ceq("R6", "strobe stretched by wait", o_st[0], 7);
      ceq("R6", "strobe after release", o_st[1], 2);
      ceq("R7", "hold zero count", o_hd[0], 1);
      idle_gap();
   endtask

   task automatic test_cfg_latch();
      issue(20'h00500, 32'hCAFEF00D, 4'b1010, 2'd0, 1'b1, 1, 1, 2, 2);
      drop_valid();
      fork
         begin
            @(negedge clk);
            while (mem_we_n) @(negedge clk);
            cfg_setup = 4'd5; cfg_strobe = 6'd7; cfg_hold = 3'd6;
         end
      join_none
      observe();
      ceq("R9", "first setup", o_su[0], 2);
      ceq("R9", "second setup uses captured", o_su[1], 2);
      ceq("R9", "second strobe uses captured", o_st[1], 3);
      ceq("R9", "second hold uses captured", o_hd[1], 3);
      ceq("R5", "mask access0 be", o_bm[0], 2'b01);
      idle_gap();
   endtask

   task automatic test_chain();
      bit ack_in_hold = 0;
      issue(20'h00010, 32'h01020304, 4'b1111, 2'd0, 1'b1, 0, 0, 0, 0);
      fork
         begin
            @(posedge clk); #0.5;
            req_addr = 20'h00020; req_data = 32'h0A0B0C0D; req_prev = 2'd2;
            @(negedge clk);
            while (!req_ack) @(negedge clk);
            ack_in_hold = !mem_cs_n && mem_we_n;
            @(posedge clk); #0.5 req_valid = 1'b0;
         end
      join_none
      observe();
      ceq("R11", "second ack during final hold", ack_in_hold, 1);
      ceq("R10", "done with chained request", o_done, 1);
      ceq("R10", "cs stays low into next setup", o_cs_end, 0);
      ceq("R10", "next address at done", o_addr_end, {20'h00020, 1'b0});
      begin
         bit seen = 0;
         for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            if (wr_done) begin seen = 1; break; end
         end
         ceq("R10", "chained request completes", seen, 1);
      end
      @(negedge clk);
      ceq("R11", "no ack while idle without valid", req_ack, 0);
      idle_gap();
   endtask

   initial begin
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_basic();
      test_prev_write();
      test_prev_read();
      test_abort();
      test_wait();
      test_cfg_latch();
      test_chain();
      ceq("R1", "oe never low", oe_bad, 0);
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule